// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation table held in memory. A requester pulses `start` with the virtual address, the table base value and a flag that enables tiny-page support. The walker then fetches descriptors one word at a time over a simple read port. A walk reads either one descriptor (a section or a fault) or two (a page reached through a coarse or fine table).

The walk ends with a one-cycle `done` pulse and a status code. When the status is ok, the physical address and the two cacheable/bufferable attribute bits are valid. A walk can also end with a translation fault, or with a bus error when the memory flags a read as failed. The result outputs keep their values until the next walk completes. The walker does not cache translations and does not check access rights.

Top module: `table_walker`

## Requirements
- R1: The first descriptor is read from address {base[31:14], va[31:20], 2'b00}. The low 14 bits of the base value are ignored.
- R2: A first-level descriptor with low bits 00 ends the walk with status 01 (translation fault) after one read.
- R3: A first-level descriptor with low bits 11 ends the walk with status 01 after one read when tiny-page support is 0. When support is 1, the descriptor is treated as a fine table.
- R4: A first-level descriptor with low bits 10 is a section. The walk ends after one read with status 00, pa = {desc[31:20], va[19:0]} and attr = desc[3:2].
- R5: A first-level descriptor with low bits 01 is a coarse table. The second read goes to {desc[31:10], va[19:12], 2'b00}.
- R6: A fine-table first-level descriptor (low bits 11, support enabled) sends the second read to {desc[31:12], va[19:10], 2'b00}.
- R7: The low bits of the second-level descriptor select the page type. 00 gives status 01. 01 gives pa = {desc[31:16], va[15:0]}. 10 gives pa = {desc[31:12], va[11:0]}. 11 gives pa = {desc[31:10], va[9:0]}. Each of the three page types gives status 00.
- R8: For every second-level page, attr = desc[3:2].
- R9: A read answered with `mem_err` high ends the walk at once with status 10 (bus error). This applies to either read.
- R10: Each read is a one-cycle `mem_req` pulse. A new read is issued only after the previous one has been answered, and a walk issues at most two reads.
- R11: `busy` is high from the cycle after an accepted start until the cycle after `done`. A `start` pulse while `busy` is high is ignored: it does not change the addresses read or the result.
- R12: A walk completes with `done` high for exactly one cycle. Status is 00 ok, 01 translation fault or 10 bus error. On a fault or bus error, pa and attr read as zero.
- R13: `pa`, `attr` and `status` change only in a cycle where `done` is high.
- R14: After reset, `busy`, `done` and `mem_req` are low and `pa`, `attr` and `status` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a walk (used only when idle) |
| va | input | 32 | Virtual address to translate |
| tbase | input | 32 | Table base value (bits 31:14 used) |
| tiny_en | input | 1 | Tiny-page support enable |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 00 ok, 01 translation fault, 10 bus error |
| pa | output | 32 | Physical address result |
| attr | output | 2 | Cacheable/bufferable bits of the result |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | 32 | Read word address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_err | input | 1 | Read response is an error |

## Verification
The hardest states to reach from the ports are a `start` arriving while a read is still outstanding, and a bus error on the second read after a valid table descriptor. The bench's memory responder holds each answer back by a varying number of cycles. During some of those gaps it pulses `start` with a different address, then checks that the addresses read and the result belong to the original walk. The sweep crosses every first-level type with every second-level type, both tiny-page settings, and error injection on the first read, the second read or neither. Each expected outcome is computed arithmetically from the descriptor bit fields.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int AW      = 32;
  localparam int ATTR_W  = 2;
  localparam int KIND_W  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_DONE
  } tw_state_e;

  typedef enum logic [1:0] {
    TW_OK      = 2'b00,
    TW_XFAULT  = 2'b01,
    TW_BUS_ERR = 2'b10
  } tw_status_e;

  localparam logic [KIND_W-1:0] K_FAULT  = 2'b00;
  localparam logic [KIND_W-1:0] K_COARSE = 2'b01;
  localparam logic [KIND_W-1:0] K_SECT   = 2'b10;
  localparam logic [KIND_W-1:0] K_FINE   = 2'b11;
endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
  import tw_pkg::*;
(
  input  logic [AW-1:0] va,
  input  logic [AW-1:0] tbase,
  input  logic [AW-1:0] l1_desc,
  output logic [AW-1:0] l1_addr,
  output logic [AW-1:0] l2_addr
);
  logic unused_ag;
  assign unused_ag = ^{tbase[13:0], va[9:0], l1_desc[9:2]};

  // first-level index: va[31:20] word index under a 16 KiB aligned base
  assign l1_addr = {tbase[31:14], va[31:20], 2'b00};

  // second-level index width depends on the table kind
  always_comb begin
    if (l1_desc[KIND_W-1:0] == K_FINE)
      l2_addr = {l1_desc[31:12], va[19:10], 2'b00};
    else
      l2_addr = {l1_desc[31:10], va[19:12], 2'b00};
  end
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
  import tw_pkg::*;
#(
  parameter bit SECOND_LVL = 1'b0
) (
  input  logic [AW-1:0]     desc,
  input  logic [AW-1:0]     va,
  input  logic              tiny_en,
  output logic              fault,
  output logic              leaf,
  output logic [AW-1:0]     pa,
  output logic [ATTR_W-1:0] attr
);
  logic [KIND_W-1:0] kind;
  assign kind = desc[KIND_W-1:0];
  assign attr = desc[3:2];

  generate
    if (SECOND_LVL) begin : g_lvl2
      logic unused_l2;
      assign unused_l2 = ^{tiny_en, desc[9:4], va[31:16]};
      assign fault = (kind == K_FAULT);
      assign leaf  = 1'b1;
      always_comb begin
        case (kind)
          2'b01:   pa = {desc[31:16], va[15:0]};
          2'b10:   pa = {desc[31:12], va[11:0]};
          2'b11:   pa = {desc[31:10], va[9:0]};
          default: pa = '0;
        endcase
      end
    end else begin : g_lvl1
      logic unused_l1;
      assign unused_l1 = ^{desc[19:4], va[31:20]};
      assign fault = (kind == K_FAULT) || ((kind == K_FINE) && !tiny_en);
      assign leaf  = (kind == K_SECT);
      assign pa    = {desc[31:20], va[19:0]};
    end
  endgenerate
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mem_rvalid,
  input  logic              mem_err,
  input  logic              l1_fault,
  input  logic              l1_leaf,
  input  logic [AW-1:0]     l1_pa,
  input  logic [ATTR_W-1:0] l1_attr,
  input  logic              l2_fault,
  input  logic [AW-1:0]     l2_pa,
  input  logic [ATTR_W-1:0] l2_attr,
  output logic              accept,
  output logic              l1_load,
  output logic              sel_l2,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic [1:0]        status,
  output logic [AW-1:0]     pa,
  output logic [ATTR_W-1:0] attr
);
  tw_state_e   state_q, state_d;
  logic        res_ld;
  tw_status_e  res_st_d;
  logic [AW-1:0]     res_pa_d;
  logic [ATTR_W-1:0] res_attr_d;
  tw_status_e  status_q;
  logic [AW-1:0]     pa_q;
  logic [ATTR_W-1:0] attr_q;

  always_comb begin
    state_d    = state_q;
    res_ld     = 1'b0;
    res_st_d   = TW_OK;
    res_pa_d   = '0;
    res_attr_d = '0;
    l1_load    = 1'b0;
    case (state_q)
      ST_IDLE:    if (start) state_d = ST_L1_REQ;
      ST_L1_REQ:  state_d = ST_L1_WAIT;
      ST_L1_WAIT: begin
        if (mem_rvalid) begin
          if (mem_err) begin
            state_d = ST_DONE; res_ld = 1'b1; res_st_d = TW_BUS_ERR;
          end else if (l1_fault) begin
            state_d = ST_DONE; res_ld = 1'b1; res_st_d = TW_XFAULT;
          end else if (l1_leaf) begin
            state_d = ST_DONE; res_ld = 1'b1;
            res_pa_d = l1_pa; res_attr_d = l1_attr;
          end else begin
            state_d = ST_L2_REQ; l1_load = 1'b1;
          end
        end
      end
      ST_L2_REQ:  state_d = ST_L2_WAIT;
      ST_L2_WAIT: begin
        if (mem_rvalid) begin
          state_d = ST_DONE;
          res_ld  = 1'b1;
          if (mem_err) begin
            res_st_d = TW_BUS_ERR;
          end else if (l2_fault) begin
            res_st_d = TW_XFAULT;
          end else begin
            res_pa_d = l2_pa; res_attr_d = l2_attr;
          end
        end
      end
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= TW_OK;
      pa_q     <= '0;
      attr_q   <= '0;
    end else if (res_ld) begin
      status_q <= res_st_d;
      pa_q     <= res_pa_d;
      attr_q   <= res_attr_d;
    end
  end

  assign accept  = (state_q == ST_IDLE) && start;
  assign sel_l2  = (state_q == ST_L2_REQ);
  assign busy    = (state_q != ST_IDLE);
  assign done    = (state_q == ST_DONE);
  assign mem_req = (state_q == ST_L1_REQ) || (state_q == ST_L2_REQ);
  assign status  = status_q;
  assign pa      = pa_q;
  assign attr    = attr_q;
endmodule

// File: rtl/table_walker.sv
module table_walker
  import tw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     va,
  input  logic [AW-1:0]     tbase,
  input  logic              tiny_en,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic [AW-1:0]     pa,
  output logic [ATTR_W-1:0] attr,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_rvalid,
  input  logic [AW-1:0]     mem_rdata,
  input  logic              mem_err
);
  logic [AW-1:0] va_q, tbase_q, l1_q;
  logic          tiny_q;
  logic          accept, l1_load, sel_l2;
  logic [AW-1:0] l1_addr, l2_addr;
  logic          l1_fault, l1_leaf, l2_fault, l2_leaf;
  logic [AW-1:0] l1_pa, l2_pa;
  logic [ATTR_W-1:0] l1_attr, l2_attr;
  logic unused_top;
  assign unused_top = l2_leaf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q    <= '0;
      tbase_q <= '0;
      tiny_q  <= 1'b0;
    end else if (accept) begin
      va_q    <= va;
      tbase_q <= tbase;
      tiny_q  <= tiny_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       l1_q <= '0;
    else if (l1_load) l1_q <= mem_rdata;
  end

  tw_addr_gen u_addr (
    .va(va_q), .tbase(tbase_q), .l1_desc(l1_q),
    .l1_addr(l1_addr), .l2_addr(l2_addr)
  );

  tw_desc_decode #(.SECOND_LVL(1'b0)) u_dec_l1 (
    .desc(mem_rdata), .va(va_q), .tiny_en(tiny_q),
    .fault(l1_fault), .leaf(l1_leaf), .pa(l1_pa), .attr(l1_attr)
  );

  tw_desc_decode #(.SECOND_LVL(1'b1)) u_dec_l2 (
    .desc(mem_rdata), .va(va_q), .tiny_en(tiny_q),
    .fault(l2_fault), .leaf(l2_leaf), .pa(l2_pa), .attr(l2_attr)
  );

  tw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_rvalid(mem_rvalid), .mem_err(mem_err),
    .l1_fault(l1_fault), .l1_leaf(l1_leaf), .l1_pa(l1_pa), .l1_attr(l1_attr),
    .l2_fault(l2_fault), .l2_pa(l2_pa), .l2_attr(l2_attr),
    .accept(accept), .l1_load(l1_load), .sel_l2(sel_l2),
    .busy(busy), .done(done), .mem_req(mem_req),
    .status(status), .pa(pa), .attr(attr)
  );

  assign mem_addr = sel_l2 ? l2_addr : l1_addr;
endmodule

// File: rtl/table_walker_chk.sv
module table_walker_chk
  import tw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [1:0]        status,
  input logic [AW-1:0]     pa,
  input logic [ATTR_W-1:0] attr,
  input logic              mem_req
);
  // R10
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R12
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && mem_req));

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);

  // R12
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (status != 2'b11));

  // R13
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(pa) && $stable(attr) && $stable(status)));
endmodule

bind table_walker table_walker_chk u_tw_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .status(status), .pa(pa), .attr(attr), .mem_req(mem_req)
);

// File: tb/table_walker_bench.sv
module table_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] va = '0, tbase = '0;
  logic        tiny_en = 1'b0;
  logic        busy, done, mem_req;
  logic [1:0]  status, attr;
  logic [31:0] pa, mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;
  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  table_walker u_table_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .tbase(tbase),
    .tiny_en(tiny_en), .busy(busy), .done(done), .status(status), .pa(pa),
    .attr(attr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_err(mem_err)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic run_walk(input logic [31:0] v, input logic [31:0] tb, input logic tiny,
                          input logic [31:0] d1, input logic [31:0] d2,
                          input logic e1, input logic e2, input int lat, input logic poke);
    int          exp_n;
    logic [31:0] exp_a1, exp_a2, exp_pa;
    logic [1:0]  exp_st, exp_attr;
    string       st_tag, attr_tag, a2_tag;
    int          nreads;
    logic [31:0] got_a [2];
    logic [31:0] got_pa;
    logic [1:0]  got_st, got_attr;
    bit          got_done;
    int          cyc;

    // expected outcome from the descriptor bit fields
    exp_a1 = {tb[31:14], v[31:20], 2'b00};
    exp_a2 = '0; exp_pa = '0; exp_attr = 2'b00; exp_n = 1;
    a2_tag = "R5 coarse L2 address"; attr_tag = "R4 section attr";
    if (e1) begin
      exp_st = 2'b10; st_tag = "R9 bus error L1";
    end else if (d1[1:0] == 2'b00) begin
      exp_st = 2'b01; st_tag = "R2 L1 fault";
    end else if (d1[1:0] == 2'b11 && !tiny) begin
      exp_st = 2'b01; st_tag = "R3 fine without tiny support";
    end else if (d1[1:0] == 2'b10) begin
      exp_st = 2'b00; st_tag = "R4 section";
      exp_pa = {d1[31:20], v[19:0]}; exp_attr = d1[3:2];
    end else begin
      exp_n = 2;
      if (d1[1:0] == 2'b11) begin
        exp_a2 = {d1[31:12], v[19:10], 2'b00}; a2_tag = "R6 fine L2 address";
      end else begin
        exp_a2 = {d1[31:10], v[19:12], 2'b00};
      end
      attr_tag = "R8 page attr";
      if (e2) begin
        exp_st = 2'b10; st_tag = "R9 bus error L2";
      end else if (d2[1:0] == 2'b00) begin
        exp_st = 2'b01; st_tag = "R7 L2 fault";
      end else begin
        exp_st = 2'b00; st_tag = "R7 page";
        exp_attr = d2[3:2];
        case (d2[1:0])
          2'b01:   exp_pa = {d2[31:16], v[15:0]};
          2'b10:   exp_pa = {d2[31:12], v[11:0]};
          default: exp_pa = {d2[31:10], v[9:0]};
        endcase
      end
    end

    @(negedge clk);
    start = 1'b1; va = v; tbase = tb; tiny_en = tiny;
    @(negedge clk);
    start = 1'b0; va = ~v; tbase = ~tb; tiny_en = ~tiny;
    nreads = 0; got_done = 0; cyc = 0;
    got_a[0] = '0; got_a[1] = '0; got_pa = '0; got_st = '0; got_attr = '0;
    while (!got_done && cyc < 40) begin
      if (done) begin
        got_done = 1; got_pa = pa; got_st = status; got_attr = attr;
      end else if (mem_req) begin
        if (nreads < 2) got_a[nreads] = mem_addr;
        nreads++;
        @(negedge clk);
        if (poke) begin start = 1'b1; va = v ^ 32'hFFF0_0000; end
        repeat (lat) @(negedge clk);
        start = 1'b0;
        mem_rvalid = 1'b1;
        mem_rdata  = (nreads == 1) ? d1 : d2;
        mem_err    = (nreads == 1) ? e1 : e2;
        @(negedge clk);
        mem_rvalid = 1'b0; mem_err = 1'b0; mem_rdata = 32'hDEAD_BEEF;
      end else begin
        @(negedge clk);
      end
      cyc++;
    end
    check("R12 walk completes", 32'(got_done), 32'd1);
    check("R10 read count", nreads, exp_n);
    check("R1 L1 address", got_a[0], exp_a1);
    if (exp_n == 2) check(a2_tag, got_a[1], exp_a2);
    check(st_tag, 32'(got_st), 32'(exp_st));
    check({st_tag, " pa"}, got_pa, exp_pa);
    check(attr_tag, 32'(got_attr), 32'(exp_attr));
    @(negedge clk);
    check("R12 done single cycle", 32'(done), 32'd0);
    check("R11 busy cleared", 32'(busy), 32'd0);
    @(negedge clk);
    check("R13 pa held", pa, exp_pa);
    check("R13 status held", 32'(status), 32'(exp_st));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R14 reset busy", 32'(busy), 32'd0);
    check("R14 reset done", 32'(done), 32'd0);
    check("R14 reset mem_req", 32'(mem_req), 32'd0);
    check("R14 reset pa", pa, 32'd0);
    check("R14 reset attr", 32'(attr), 32'd0);
    check("R14 reset status", 32'(status), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R14 idle after release", 32'(busy), 32'd0);

    begin
      int idx = 0;
      for (int t1 = 0; t1 < 4; t1++)
        for (int t2 = 0; t2 < 4; t2++)
          for (int tn = 0; tn < 2; tn++)
            for (int ep = 0; ep < 3; ep++)
              for (int vi = 0; vi < 2; vi++) begin
                logic [31:0] v, tb, d1, d2;
                int lat;
                logic poke;
                v  = (vi != 0 ? 32'hC3A5_9E17 : 32'h1234_5678) ^ (32'(t2) << 13);
                tb = 32'h4000_0000 | (32'(idx) << 14) | 32'h0000_3ABC;
                d1 = ((32'hA000_0000 ^ (32'(idx) * 32'h0001_3579)) & ~32'hF)
                     | (32'(idx % 4) << 2) | 32'(t1);
                d2 = ((32'h5000_0000 ^ (32'(idx) * 32'h0002_468B)) & ~32'hF)
                     | (32'((idx + 1) % 4) << 2) | 32'(t2);
                lat  = idx % 3;
                poke = (lat != 0) && (idx % 5 == 1);
                run_walk(v, tb, tn[0], d1, d2, ep == 1, ep == 2, lat, poke);
                idx++;
              end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule